// File: doc/BRIEF.md
# Dual-Address I2C Slave

This block is an I2C target that answers two separate address groups on one bus. Group A covers four consecutive 7-bit addresses, because its compare ignores the two lowest address bits. It reports those two bits so the surrounding logic can tell which of the four addresses was used. Group B answers one exact 7-bit address. Each group has a one-byte transmit holding register and a one-byte receive register. Transmit data is written from the core side. Received bytes are announced with a one-cycle event.

The bus lines are sampled by the system clock through a synchronizer. START and STOP are recognised from SDA edges while SCL is high. Data is sampled on SCL rising edges, and the slave changes SDA only while SCL is low. For a read, if the group's transmit register is empty when the next byte must go out, the slave holds SCL low until the core writes a byte. Status outputs give:

- whether a transaction is open;
- the transfer direction;
- whether the host refused the last transmitted byte;
- whether the host is holding SCL low;
- whether the received byte was the first of a write, and so a word address.

Top module: `i2c_dual_slave`

## Requirements
- R1: `slave_active` is 0 after reset, becomes 1 after a START (SDA falling while SCL high) and returns to 0 after a STOP (SDA rising while SCL high).
- R2: Group A matches when address bits 6..2 of the received 7-bit address equal `addr_a[6:2]`; `addr_a[1:0]` are ignored. On a match `match_a_evt` pulses for one cycle and `lsb_a` holds address bits 1..0.
- R3: Group B matches only when all 7 address bits equal `addr_b` and pulses `match_b_evt`. When both groups match, only group A responds.
- R4: An address that matches neither group gets no ACK (SDA stays released in the ninth clock), and later bytes up to the next START produce no event and no change on the receive outputs.
- R5: The slave pulls SDA low during the ninth clock after a matched address and after each byte it receives.
- R6: `dir_tx` takes the R/W bit of the matched address byte (bit 0 of the byte; 1 = read, slave transmits; 0 = write, slave receives).
- R7: Each received byte appears on the group's `rx_*_data`, together with a one-cycle `rx_*_evt`, after its eighth bit.
- R8: `word_*` is 1 for the first byte received after a write-direction address match (including one after a repeated START), and 0 for every later byte of that transfer.
- R9: In a read, bytes are sent MSB first from the group's transmit register. `tx_*_empty` is 1 after reset and once the byte has been taken, and is 0 after a write strobe.
- R10: `host_nack` goes to 1 when the host answers a transmitted byte with NACK and is cleared by the next address match. After a NACK the slave drives SDA no further.
- R11: If the transmit register is empty when a byte must be sent, `scl_oe` holds SCL low until the register is written. The byte then goes out normally.
- R12: `scl_busy` is 1 while SCL is low because of the host, not the slave's own stretch, and 0 while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_a | input | 7 | Group A base address (low two bits ignored) |
| addr_b | input | 7 | Group B exact address |
| tx_a_wr | input | 1 | Write strobe for group A transmit register |
| tx_a_data | input | 8 | Group A transmit byte |
| tx_b_wr | input | 1 | Write strobe for group B transmit register |
| tx_b_data | input | 8 | Group B transmit byte |
| tx_a_empty | output | 1 | Group A transmit register needs a byte |
| tx_b_empty | output | 1 | Group B transmit register needs a byte |
| rx_a_data | output | 8 | Last byte received by group A |
| rx_b_data | output | 8 | Last byte received by group B |
| rx_a_evt | output | 1 | One-cycle pulse: new group A byte |
| rx_b_evt | output | 1 | One-cycle pulse: new group B byte |
| word_a | output | 1 | Group A byte is a word address |
| word_b | output | 1 | Group B byte is a word address |
| match_a_evt | output | 1 | One-cycle pulse: group A address match |
| match_b_evt | output | 1 | One-cycle pulse: group B address match |
| lsb_a | output | 2 | Low two address bits of the last group A match |
| dir_tx | output | 1 | 1 slave transmit, 0 slave receive |
| host_nack | output | 1 | Host refused the last transmitted byte |
| slave_active | output | 1 | A START has been seen and no STOP since |
| scl_busy | output | 1 | Host is holding SCL low |

## Verification
A wrong bit counter or a misrouted group index shows at the ports within one byte time. The bad index sends an event to the wrong group, or gives a wrong word-address flag, or places the ACK in the wrong clock, which the host sees in the ninth bit. A stuck transmit-full flag shows up as a wrong byte on the bus, or as a stretch that never ends. A wrong stretch state shows as an SCL low that outlives the core's write by more than a few clocks. The event order is compared item by item against a queue of expected matches and bytes, so a missing, extra or reordered event is caught on the pulse where it happens.

// File: rtl/i2cd_pkg.sv
package i2cd_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int NGRP   = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RXD,
        ST_RACK,
        ST_TXD,
        ST_TACK,
        ST_TWAIT
    } eng_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              word;
    } rx_item_t;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] got,
                                      input logic [ADDR_W-1:0] base,
                                      input int              ign);
        logic [ADDR_W-1:0] keep;
        keep = '1;
        keep = keep << ign;
        return ((got ^ base) & keep) == '0;
    endfunction
endpackage

// File: rtl/i2cd_line_sync.sv
module i2cd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_p[STAGES-1];
        sda_s     = sda_p[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cd_grp_buf.sv
module i2cd_grp_buf
    import i2cd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  rx_item_t          rx_item,
    output logic              tx_full,
    output logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_word,
    output logic              rx_evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_full <= 1'b0;
            tx_data <= '0;
        end else if (tx_wr) begin
            tx_full <= 1'b1;
            tx_data <= tx_wdata;
        end else if (tx_pop) begin
            tx_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_word <= 1'b0;
            rx_evt  <= 1'b0;
        end else begin
            rx_evt <= rx_push;
            if (rx_push) begin
                rx_data <= rx_item.data;
                rx_word <= rx_item.word;
            end
        end
    end

    AST_POP_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> tx_full); // R9
endmodule

// File: rtl/i2cd_engine.sv
module i2cd_engine
    import i2cd_pkg::*;
#(
    parameter int MASK_A = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_s,
    input  logic                        sda_s,
    input  logic                        scl_rise,
    input  logic                        scl_fall,
    input  logic                        start_det,
    input  logic                        stop_det,
    input  logic [ADDR_W-1:0]           addr_a,
    input  logic [ADDR_W-1:0]           addr_b,
    input  logic [NGRP-1:0]             tx_full,
    input  logic [NGRP-1:0][BYTE_W-1:0] tx_data,
    output logic [NGRP-1:0]             tx_pop,
    output logic [NGRP-1:0]             rx_push,
    output rx_item_t                    rx_item,
    output logic [NGRP-1:0]             match_evt,
    output logic [MASK_A-1:0]           lsb_a,
    output logic                        sda_oe,
    output logic                        scl_oe,
    output logic                        slave_active,
    output logic                        dir_tx,
    output logic                        host_nack,
    output logic                        scl_busy
);
    eng_st_t           st;
    logic [BYTE_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              grp;
    logic              matched;
    logic              first;
    logic [BYTE_W-1:0] sh_in;
    logic [ADDR_W-1:0] got_addr;
    logic              hit_a, hit_b;

    always_comb begin
        sh_in    = {sr[BYTE_W-2:0], sda_s};
        got_addr = sh_in[BYTE_W-1:1];
        hit_a    = addr_hit(got_addr, addr_a, MASK_A);
        hit_b    = addr_hit(got_addr, addr_b, 0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            sr           <= '0;
            cnt          <= '0;
            grp          <= 1'b0;
            matched      <= 1'b0;
            first        <= 1'b0;
            sda_oe       <= 1'b0;
            scl_oe       <= 1'b0;
            slave_active <= 1'b0;
            dir_tx       <= 1'b0;
            host_nack    <= 1'b0;
            scl_busy     <= 1'b0;
            lsb_a        <= '0;
            tx_pop       <= '0;
            rx_push      <= '0;
            match_evt    <= '0;
            rx_item      <= '0;
        end else begin
            tx_pop    <= '0;
            rx_push   <= '0;
            match_evt <= '0;
            scl_busy  <= ~scl_s & ~scl_oe;
            if (start_det) begin
                st           <= ST_ADDR;
                cnt          <= '0;
                sda_oe       <= 1'b0;
                scl_oe       <= 1'b0;
                slave_active <= 1'b1;
            end else if (stop_det) begin
                st           <= ST_IDLE;
                sda_oe       <= 1'b0;
                scl_oe       <= 1'b0;
                slave_active <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sr  <= sh_in;
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                matched <= hit_a | hit_b;
                                if (hit_a) begin
                                    grp          <= 1'b0;
                                    lsb_a        <= got_addr[MASK_A-1:0];
                                    match_evt[0] <= 1'b1;
                                    dir_tx       <= sda_s;
                                    host_nack    <= 1'b0;
                                end else if (hit_b) begin
                                    grp          <= 1'b1;
                                    match_evt[1] <= 1'b1;
                                    dir_tx       <= sda_s;
                                    host_nack    <= 1'b0;
                                end
                            end
                        end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            if (matched) begin
                                sda_oe <= 1'b1;
                                st     <= ST_AACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            if (!dir_tx) begin
                                first <= 1'b1;
                                st    <= ST_RXD;
                            end else if (tx_full[grp]) begin
                                sr          <= tx_data[grp];
                                tx_pop[grp] <= 1'b1;
                                sda_oe      <= ~tx_data[grp][BYTE_W-1];
                                st          <= ST_TXD;
                            end else begin
                                scl_oe <= 1'b1;
                                st     <= ST_TWAIT;
                            end
                        end
                    end
                    ST_RXD: begin
                        if (scl_rise) begin
                            sr  <= sh_in;
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                rx_push[grp] <= 1'b1;
                                rx_item.data <= sh_in;
                                rx_item.word <= first;
                                first        <= 1'b0;
                            end
                        end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            sda_oe <= 1'b1;
                            st     <= ST_RACK;
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            st     <= ST_RXD;
                        end
                    end
                    ST_TXD: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                st     <= ST_TACK;
                            end else begin
                                sr     <= {sr[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sr[BYTE_W-2];
                            end
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise) begin
                            host_nack <= sda_s;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (host_nack) begin
                                st <= ST_IDLE;
                            end else if (tx_full[grp]) begin
                                sr          <= tx_data[grp];
                                tx_pop[grp] <= 1'b1;
                                sda_oe      <= ~tx_data[grp][BYTE_W-1];
                                st          <= ST_TXD;
                            end else begin
                                scl_oe <= 1'b1;
                                st     <= ST_TWAIT;
                            end
                        end
                    end
                    ST_TWAIT: begin
                        if (tx_full[grp]) begin
                            sr          <= tx_data[grp];
                            tx_pop[grp] <= 1'b1;
                            sda_oe      <= ~tx_data[grp][BYTE_W-1];
                            scl_oe      <= 1'b0;
                            cnt         <= '0;
                            st          <= ST_TXD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
        start_det |=> slave_active); // R1
    AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (stop_det && !start_det) |=> !slave_active); // R1
    AST_ONE_GROUP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_evt)); // R3
    AST_SDA_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s)); // R5
    AST_STRETCH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && $past(scl_oe)) |-> !$past(tx_full[grp])); // R11
endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave
    import i2cd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MASK_A      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              tx_a_wr,
    input  logic [BYTE_W-1:0] tx_a_data,
    input  logic              tx_b_wr,
    input  logic [BYTE_W-1:0] tx_b_data,
    output logic              tx_a_empty,
    output logic              tx_b_empty,
    output logic [BYTE_W-1:0] rx_a_data,
    output logic [BYTE_W-1:0] rx_b_data,
    output logic              rx_a_evt,
    output logic              rx_b_evt,
    output logic              word_a,
    output logic              word_b,
    output logic              match_a_evt,
    output logic              match_b_evt,
    output logic [MASK_A-1:0] lsb_a,
    output logic              dir_tx,
    output logic              host_nack,
    output logic              slave_active,
    output logic              scl_busy
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    logic [NGRP-1:0]             tx_wr, tx_full, tx_pop, rx_push, rx_evt, rx_word;
    logic [NGRP-1:0][BYTE_W-1:0] tx_wdata, tx_data, rx_data;
    logic [NGRP-1:0]             match_evt;
    rx_item_t                    rx_item;

    i2cd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cd_engine #(.MASK_A(MASK_A)) u_eng (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .addr_a(addr_a), .addr_b(addr_b),
        .tx_full(tx_full), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_item(rx_item), .match_evt(match_evt),
        .lsb_a(lsb_a), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .slave_active(slave_active), .dir_tx(dir_tx),
        .host_nack(host_nack), .scl_busy(scl_busy)
    );

    assign tx_wr    = {tx_b_wr, tx_a_wr};
    assign tx_wdata = {tx_b_data, tx_a_data};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        i2cd_grp_buf u_buf (
            .clk(clk), .rst(rst),
            .tx_wr(tx_wr[g]), .tx_wdata(tx_wdata[g]), .tx_pop(tx_pop[g]),
            .rx_push(rx_push[g]), .rx_item(rx_item),
            .tx_full(tx_full[g]), .tx_data(tx_data[g]),
            .rx_data(rx_data[g]), .rx_word(rx_word[g]), .rx_evt(rx_evt[g])
        );
    end

    assign tx_a_empty  = ~tx_full[0];
    assign tx_b_empty  = ~tx_full[1];
    assign rx_a_data   = rx_data[0];
    assign rx_b_data   = rx_data[1];
    assign rx_a_evt    = rx_evt[0];
    assign rx_b_evt    = rx_evt[1];
    assign word_a      = rx_word[0];
    assign word_b      = rx_word[1];
    assign match_a_evt = match_evt[0];
    assign match_b_evt = match_evt[1];
endmodule

// File: tb/sim_i2c_dual_slave.sv
module sim_i2c_dual_slave;
    localparam int QT = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_scl_lo = 1'b0;
    logic       host_sda_lo = 1'b0;
    logic [6:0] addr_a = 7'h53;
    logic [6:0] addr_b = 7'h2C;
    logic       tx_a_wr = 1'b0, tx_b_wr = 1'b0;
    logic [7:0] tx_a_data = 8'h00, tx_b_data = 8'h00;

    logic       scl_oe, sda_oe, tx_a_empty, tx_b_empty;
    logic [7:0] rx_a_data, rx_b_data;
    logic       rx_a_evt, rx_b_evt, word_a, word_b, match_a_evt, match_b_evt;
    logic [1:0] lsb_a;
    logic       dir_tx, host_nack, slave_active, scl_busy;
    logic       scl_line, sda_line;

    assign scl_line = ~(host_scl_lo | scl_oe);
    assign sda_line = ~(host_sda_lo | sda_oe);

    int checks = 0;
    int fails  = 0;
    logic [12:0] exp_q[$];

    always #10 clk = ~clk;

    i2c_dual_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_a(addr_a), .addr_b(addr_b),
        .tx_a_wr(tx_a_wr), .tx_a_data(tx_a_data), .tx_b_wr(tx_b_wr), .tx_b_data(tx_b_data),
        .tx_a_empty(tx_a_empty), .tx_b_empty(tx_b_empty),
        .rx_a_data(rx_a_data), .rx_b_data(rx_b_data), .rx_a_evt(rx_a_evt), .rx_b_evt(rx_b_evt),
        .word_a(word_a), .word_b(word_b), .match_a_evt(match_a_evt), .match_b_evt(match_b_evt),
        .lsb_a(lsb_a), .dir_tx(dir_tx), .host_nack(host_nack),
        .slave_active(slave_active), .scl_busy(scl_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard item: {kind[1:0], grp, aux[1:0], data[7:0]}; kind 1 = match, 2 = rx
    function automatic logic [12:0] m_item(input logic g, input logic [1:0] lsb, input logic d);
        return {2'd1, g, lsb, 7'd0, d};
    endfunction
    function automatic logic [12:0] r_item(input logic g, input logic w, input logic [7:0] b);
        return {2'd2, g, 1'b0, w, b};
    endfunction

    task automatic sb_cmp(input string req, input logic [12:0] got);
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected event actual=0x%0h expected=none", req, got);
        end else begin
            logic [12:0] e;
            e = exp_q.pop_front();
            if (e !== got) begin
                fails++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, e);
            end
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (match_a_evt) sb_cmp("R2", m_item(1'b0, lsb_a, dir_tx));
            if (match_b_evt) sb_cmp("R3", m_item(1'b1, 2'b00, dir_tx));
            if (rx_a_evt)    sb_cmp("R7/R8", r_item(1'b0, word_a, rx_a_data));
            if (rx_b_evt)    sb_cmp("R7/R8", r_item(1'b1, word_b, rx_b_data));
        end
    end

    task automatic qwait();
        repeat (QT) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda_lo = 1'b0;
        qwait();
        host_scl_lo = 1'b0;
        wait_scl_high();
        qwait();
        host_sda_lo = 1'b1;
        qwait();
        host_scl_lo = 1'b1;
        qwait();
    endtask

    task automatic bus_stop();
        host_sda_lo = 1'b1;
        qwait();
        host_scl_lo = 1'b0;
        wait_scl_high();
        qwait();
        host_sda_lo = 1'b0;
        qwait();
        qwait();
    endtask

    task automatic clk_bit(input logic one, output logic got);
        host_sda_lo = ~one;
        qwait();
        host_scl_lo = 1'b0;
        wait_scl_high();
        qwait();
        got = sda_line;
        qwait();
        host_scl_lo = 1'b1;
        qwait();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic g;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], g);
        clk_bit(1'b1, g);
        ack = ~g;
    endtask

    task automatic read_bits(output logic [7:0] v);
        logic g;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, g);
            v = {v[6:0], g};
        end
    endtask

    task automatic ack_bit(input logic nack);
        logic g;
        clk_bit(nack, g);
    endtask

    task automatic load_tx(input logic g, input logic [7:0] b);
        if (g) begin tx_b_data = b; tx_b_wr = 1'b1; end
        else   begin tx_a_data = b; tx_a_wr = 1'b1; end
        @(negedge clk);
        tx_a_wr = 1'b0;
        tx_b_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);

        // reset state
        chk("R1", slave_active, 1'b0);
        chk("R9", tx_a_empty, 1'b1);
        chk("R9", tx_b_empty, 1'b1);
        chk("R11", scl_oe, 1'b0);
        chk("R5", sda_oe, 1'b0);
        chk("R12", scl_busy, 1'b0);

        // write to group A at 0x52 (base 0x53, low bits ignored)
        bus_start();
        chk("R1", slave_active, 1'b1);
        chk("R12", scl_busy, 1'b1);
        exp_q.push_back(m_item(1'b0, 2'd2, 1'b0));
        write_byte({7'h52, 1'b0}, ack);
        chk("R5", ack, 1'b1);
        chk("R6", dir_tx, 1'b0);
        chk("R2", lsb_a, 2'd2);
        exp_q.push_back(r_item(1'b0, 1'b1, 8'h3C));
        write_byte(8'h3C, ack); chk("R5", ack, 1'b1);
        exp_q.push_back(r_item(1'b0, 1'b0, 8'hA5));
        write_byte(8'hA5, ack); chk("R5", ack, 1'b1);
        exp_q.push_back(r_item(1'b0, 1'b0, 8'h0F));
        write_byte(8'h0F, ack); chk("R5", ack, 1'b1);
        bus_stop();
        chk("R1", slave_active, 1'b0);
        chk("R12", scl_busy, 1'b0);

        // write to group B exact
        bus_start();
        exp_q.push_back(m_item(1'b1, 2'd0, 1'b0));
        write_byte({7'h2C, 1'b0}, ack); chk("R3", ack, 1'b1);
        exp_q.push_back(r_item(1'b1, 1'b1, 8'h77));
        write_byte(8'h77, ack); chk("R5", ack, 1'b1);
        exp_q.push_back(r_item(1'b1, 1'b0, 8'h81));
        write_byte(8'h81, ack); chk("R8", ack, 1'b1);
        bus_stop();

        // B off by one bit: no match
        bus_start();
        write_byte({7'h2D, 1'b0}, ack); chk("R3", ack, 1'b0);
        bus_stop();

        // unmatched address: no ACK, later byte ignored
        bus_start();
        write_byte({7'h60, 1'b0}, ack); chk("R4", ack, 1'b0);
        write_byte(8'hEE, ack); chk("R4", ack, 1'b0);
        chk("R4", rx_a_data, 8'h0F);
        chk("R4", rx_b_data, 8'h81);
        bus_stop();

        // read from group A at 0x51
        load_tx(1'b0, 8'hC3);
        chk("R9", tx_a_empty, 1'b0);
        bus_start();
        exp_q.push_back(m_item(1'b0, 2'd1, 1'b1));
        write_byte({7'h51, 1'b1}, ack); chk("R5", ack, 1'b1);
        chk("R6", dir_tx, 1'b1);
        read_bits(v);
        chk("R9", v, 8'hC3);
        chk("R9", tx_a_empty, 1'b1);
        load_tx(1'b0, 8'h5A);
        ack_bit(1'b0);
        chk("R10", host_nack, 1'b0);
        read_bits(v);
        chk("R9", v, 8'h5A);
        ack_bit(1'b1);
        chk("R10", host_nack, 1'b1);
        qwait();
        chk("R10", sda_oe, 1'b0);
        bus_stop();

        // read from group B with empty buffer: stretch
        bus_start();
        exp_q.push_back(m_item(1'b1, 2'd0, 1'b1));
        write_byte({7'h2C, 1'b1}, ack); chk("R5", ack, 1'b1);
        chk("R10", host_nack, 1'b0);
        fork
            read_bits(v);
            begin
                repeat (80) @(negedge clk);
                chk("R11", scl_oe, 1'b1);
                chk("R11", scl_line, 1'b0);
                chk("R12", scl_busy, 1'b0);
                load_tx(1'b1, 8'h96);
            end
        join
        chk("R11", v, 8'h96);
        chk("R11", scl_oe, 1'b0);
        ack_bit(1'b1);
        bus_stop();

        // both groups match 0x51: A wins
        addr_b = 7'h51;
        bus_start();
        exp_q.push_back(m_item(1'b0, 2'd1, 1'b0));
        write_byte({7'h51, 1'b0}, ack); chk("R3", ack, 1'b1);
        exp_q.push_back(r_item(1'b0, 1'b1, 8'h11));
        write_byte(8'h11, ack);
        bus_stop();
        addr_b = 7'h2C;

        // repeated START: first byte again a word address
        bus_start();
        exp_q.push_back(m_item(1'b0, 2'd0, 1'b0));
        write_byte({7'h50, 1'b0}, ack);
        exp_q.push_back(r_item(1'b0, 1'b1, 8'h22));
        write_byte(8'h22, ack);
        bus_start();
        chk("R1", slave_active, 1'b1);
        exp_q.push_back(m_item(1'b0, 2'd0, 1'b0));
        write_byte({7'h50, 1'b0}, ack);
        exp_q.push_back(r_item(1'b0, 1'b1, 8'h33));
        write_byte(8'h33, ack);
        chk("R8", word_a, 1'b1);
        bus_stop();

        repeat (10) @(negedge clk);
        chk("R7", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule